// File: doc/BRIEF.md
# PCI Bus Parity Unit

This block creates and verifies the even parity signal for one agent attached to a 32-bit multiplexed address/data PCI bus. On the send side, it forwards the agent's AD and C/BE values to the bus. It enables the bus drivers when the agent is driving an address as master or driving a data word. It also enables them when the arbiter grants an idle bus the agent never asked for, which is bus parking. One clock after each driven cycle, it drives the parity bit that covers those values.

On the receive side, the unit captures the bus contents in any cycle the transaction logic marks as a received address or a received data transfer. It compares the capture against the parity bit that arrives one clock later. A mismatch always sets a sticky detected-error status bit. Only for data transfers, and only when the command register's response enable is on, it also pulls the active-low error output low. Software clears the status bit by writing a one to it, and the write reaches the block as a one-cycle strobe.

Top module: `pci_parity_unit`

## Requirements
- R1: During a master address drive cycle (`drv_addr_i`=1), `ad_o`/`cbe_o` equal `ad_src_i`/`cbe_src_i`, and in the next cycle `par_o` is set so that the XOR of those 32 AD bits, 4 C/BE bits and `par_o` is 0.
- R2: During a data drive cycle (`drv_data_i`=1), the bus outputs and the next-cycle `par_o` follow the same rule as R1.
- R3: When `gnt_i`=1, `req_i`=0 and `bus_idle_i`=1, the unit drives `ad_oe_o`=`cbe_oe_o`=1 in that cycle, with parity as in R1 one cycle later. If `req_i`=1 and no drive control is active, the drivers stay off.
- R4: `par_oe_o` is 1 exactly in the cycle after a drive cycle (R1, R2 or R3). In every other cycle it is 0.
- R5: When an address is received (`chk_addr_i`=1) and the `par_i` sampled one cycle later does not make the XOR of the 37 bits zero, `dpe_o` becomes 1. `perr_n_o` stays 1.
- R6: A data receive (`chk_data_i`=1) with bad parity and `resp_en_i`=1 sets `dpe_o`. It also drives `perr_n_o`=0 for exactly the one cycle two clocks after the transfer cycle.
- R7: A data parity mismatch while `resp_en_i`=0 sets `dpe_o` and leaves `perr_n_o`=1.
- R8: A receive with correct parity changes neither `dpe_o` nor `perr_n_o`.
- R9: A one-cycle `stat_w1c_i` pulse clears `dpe_o` in the next cycle. If a mismatch is detected at the same edge, `dpe_o` stays 1.
- R10: After reset, `ad_oe_o`, `cbe_oe_o`, `par_oe_o` and `dpe_o` are 0 and `perr_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_addr_i | input | 1 | Agent drives an address as master this cycle |
| drv_data_i | input | 1 | Agent drives a data word this cycle |
| gnt_i | input | 1 | Bus grant seen (active high) |
| req_i | input | 1 | Agent is requesting the bus (active high) |
| bus_idle_i | input | 1 | Bus is idle |
| ad_src_i | input | 32 | AD value the agent wants on the bus |
| cbe_src_i | input | 4 | C/BE value the agent wants on the bus |
| ad_o | output | 32 | AD bus output |
| cbe_o | output | 4 | C/BE bus output |
| ad_oe_o | output | 1 | AD output enable |
| cbe_oe_o | output | 1 | C/BE output enable |
| par_o | output | 1 | Parity output |
| par_oe_o | output | 1 | Parity output enable |
| ad_i | input | 32 | AD bus as received |
| cbe_i | input | 4 | C/BE bus as received |
| par_i | input | 1 | Parity bus as received |
| chk_addr_i | input | 1 | Received address to be checked this cycle |
| chk_data_i | input | 1 | Received data transfer to be checked this cycle |
| resp_en_i | input | 1 | Parity error response enable from command register |
| stat_w1c_i | input | 1 | Software wrote one to the detected-error bit |
| perr_n_o | output | 1 | Data parity error, active low |
| dpe_o | output | 1 | Sticky detected parity error status |

## Verification
Two actions can land on the detected-error bit at the same clock edge: the software clear strobe and the setting of the bit by a parity mismatch. The bench arranges this by pulsing `stat_w1c_i` in the cycle where the late parity bit arrives for a corrupted receive. It then expects `dpe_o` to stay set, and with the response enable on it also expects the error pulse. The same clear pulse is also paired with a clean receive, and there the bench expects the bit to drop.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned AD_W  = 32;
  localparam int unsigned CBE_W = 4;

  typedef enum logic [1:0] {
    CHK_NONE = 2'd0,
    CHK_ADDR = 2'd1,
    CHK_DATA = 2'd2
  } chk_kind_e;
endpackage

// File: rtl/pci_par_xor.sv
module pci_par_xor #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             odd_o
);
  localparam int unsigned LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] lane_odd;

  // one byte lane plus its enable line per XOR group
  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign lane_odd[g] = ^{ad_i[g*LANE_W +: LANE_W], cbe_i[g]};
  end

  assign odd_o = ^lane_odd;
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_addr_i,
  input  logic             drv_data_i,
  input  logic             gnt_i,
  input  logic             req_i,
  input  logic             bus_idle_i,
  input  logic [AD_W-1:0]  ad_src_i,
  input  logic [CBE_W-1:0] cbe_src_i,
  output logic [AD_W-1:0]  ad_o,
  output logic [CBE_W-1:0] cbe_o,
  output logic             ad_oe_o,
  output logic             cbe_oe_o,
  output logic             par_o,
  output logic             par_oe_o
);
  logic park;
  logic drive_any;
  logic src_odd;
  logic par_q, par_d;
  logic par_oe_q, par_oe_d;

  pci_par_xor #(.AD_W(AD_W), .CBE_W(CBE_W)) u_xor (
    .ad_i  (ad_src_i),
    .cbe_i (cbe_src_i),
    .odd_o (src_odd)
  );

  always_comb begin
    park      = gnt_i & ~req_i & bus_idle_i;
    drive_any = drv_addr_i | drv_data_i | park;
    par_oe_d  = drive_any;
    par_d     = par_q;
    if (drive_any) begin
      par_d = src_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_q    <= par_d;
      par_oe_q <= par_oe_d;
    end
  end

  assign ad_o     = ad_src_i;
  assign cbe_o    = cbe_src_i;
  assign ad_oe_o  = drive_any;
  assign cbe_oe_o = drive_any;
  assign par_o    = par_q;
  assign par_oe_o = par_oe_q;
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             chk_addr_i,
  input  logic             chk_data_i,
  input  logic             resp_en_i,
  input  logic             stat_w1c_i,
  output logic             perr_n_o,
  output logic             dpe_o
);
  logic      rx_odd;
  chk_kind_e kind_q, kind_d;
  logic      calc_q, calc_d;
  logic      perr_n_q, perr_n_d;
  logic      dpe_q, dpe_d;
  logic      mismatch;

  pci_par_xor #(.AD_W(AD_W), .CBE_W(CBE_W)) u_xor (
    .ad_i  (ad_i),
    .cbe_i (cbe_i),
    .odd_o (rx_odd)
  );

  always_comb begin
    kind_d = CHK_NONE;
    if (chk_data_i) begin
      kind_d = CHK_DATA;
    end else if (chk_addr_i) begin
      kind_d = CHK_ADDR;
    end
    calc_d = calc_q;
    if (chk_data_i | chk_addr_i) begin
      calc_d = rx_odd;
    end
    mismatch = (kind_q != CHK_NONE) && (par_i != calc_q);
    perr_n_d = ~(mismatch && (kind_q == CHK_DATA) && resp_en_i);
    dpe_d    = dpe_q;
    if (mismatch) begin
      dpe_d = 1'b1;
    end else if (stat_w1c_i) begin
      dpe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= CHK_NONE;
      calc_q   <= 1'b0;
      perr_n_q <= 1'b1;
      dpe_q    <= 1'b0;
    end else begin
      kind_q   <= kind_d;
      calc_q   <= calc_d;
      perr_n_q <= perr_n_d;
      dpe_q    <= dpe_d;
    end
  end

  assign perr_n_o = perr_n_q;
  assign dpe_o    = dpe_q;
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_addr_i,
  input  logic             drv_data_i,
  input  logic             gnt_i,
  input  logic             req_i,
  input  logic             bus_idle_i,
  input  logic [AD_W-1:0]  ad_src_i,
  input  logic [CBE_W-1:0] cbe_src_i,
  output logic [AD_W-1:0]  ad_o,
  output logic [CBE_W-1:0] cbe_o,
  output logic             ad_oe_o,
  output logic             cbe_oe_o,
  output logic             par_o,
  output logic             par_oe_o,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             chk_addr_i,
  input  logic             chk_data_i,
  input  logic             resp_en_i,
  input  logic             stat_w1c_i,
  output logic             perr_n_o,
  output logic             dpe_o
);
  pci_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_addr_i (drv_addr_i),
    .drv_data_i (drv_data_i),
    .gnt_i      (gnt_i),
    .req_i      (req_i),
    .bus_idle_i (bus_idle_i),
    .ad_src_i   (ad_src_i),
    .cbe_src_i  (cbe_src_i),
    .ad_o       (ad_o),
    .cbe_o      (cbe_o),
    .ad_oe_o    (ad_oe_o),
    .cbe_oe_o   (cbe_oe_o),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  pci_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .par_i      (par_i),
    .chk_addr_i (chk_addr_i),
    .chk_data_i (chk_data_i),
    .resp_en_i  (resp_en_i),
    .stat_w1c_i (stat_w1c_i),
    .perr_n_o   (perr_n_o),
    .dpe_o      (dpe_o)
  );
endmodule

// File: rtl/pci_parity_unit_sva.sv
module pci_parity_unit_sva (
  input logic clk,
  input logic rst_n,
  input logic drv_addr_i,
  input logic drv_data_i,
  input logic gnt_i,
  input logic req_i,
  input logic bus_idle_i,
  input logic ad_oe_o,
  input logic cbe_oe_o,
  input logic par_oe_o,
  input logic chk_addr_i,
  input logic chk_data_i,
  input logic resp_en_i,
  input logic perr_n_o,
  input logic dpe_o
);
  assert_park_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_i && !req_i && bus_idle_i) |-> (ad_oe_o && cbe_oe_o));

  assert_par_oe_after_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |=> par_oe_o);

  assert_par_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_o |=> !par_oe_o);

  assert_addr_no_perr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chk_addr_i, 2) && !$past(chk_data_i, 2)) |-> perr_n_o);

  assert_perr_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> ($past(chk_data_i, 2) && dpe_o));

  assert_perr_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(resp_en_i));

  assert_dpe_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpe_o) |-> ($past(chk_addr_i, 2) || $past(chk_data_i, 2)));
endmodule

bind pci_parity_unit pci_parity_unit_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .drv_addr_i (drv_addr_i),
  .drv_data_i (drv_data_i),
  .gnt_i      (gnt_i),
  .req_i      (req_i),
  .bus_idle_i (bus_idle_i),
  .ad_oe_o    (ad_oe_o),
  .cbe_oe_o   (cbe_oe_o),
  .par_oe_o   (par_oe_o),
  .chk_addr_i (chk_addr_i),
  .chk_data_i (chk_data_i),
  .resp_en_i  (resp_en_i),
  .perr_n_o   (perr_n_o),
  .dpe_o      (dpe_o)
);

// File: tb/pci_parity_unit_bench.sv
`timescale 1ns/1ps
module pci_parity_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        drv_addr_i, drv_data_i, gnt_i, req_i, bus_idle_i;
  logic [31:0] ad_src_i;
  logic [3:0]  cbe_src_i;
  logic [31:0] ad_o;
  logic [3:0]  cbe_o;
  logic        ad_oe_o, cbe_oe_o, par_o, par_oe_o;
  logic [31:0] ad_i;
  logic [3:0]  cbe_i;
  logic        par_i, chk_addr_i, chk_data_i, resp_en_i, stat_w1c_i;
  logic        perr_n_o, dpe_o;

  int n_chk;
  int n_fail;
  int cycles;
  logic exp_dpe;

  pci_parity_unit u_pci_parity_unit (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [31:0] a, input logic [3:0] c);
    logic s;
    s = 1'b0;
    for (int k = 0; k < 32; k++) s = s ^ a[k];
    for (int k = 0; k < 4; k++) s = s ^ c[k];
    return s;
  endfunction

  // mode 0: address, 1: data, 2: parking
  task automatic send(input logic [31:0] a, input logic [3:0] c, input int mode, input string req);
    @(negedge clk);
    ad_src_i   = a;
    cbe_src_i  = c;
    drv_addr_i = (mode == 0);
    drv_data_i = (mode == 1);
    gnt_i      = (mode == 2);
    req_i      = 1'b0;
    bus_idle_i = (mode == 2);
    #1;
    check(req, {ad_oe_o, cbe_oe_o}, 2'b11);
    check(req, ad_o, a);
    check(req, {28'd0, cbe_o}, {28'd0, c});
    @(negedge clk);
    drv_addr_i = 1'b0; drv_data_i = 1'b0; gnt_i = 1'b0; bus_idle_i = 1'b0;
    ad_src_i = ~a;
    check(req, {31'd0, par_o}, {31'd0, even_bit(a, c)});
    check("R4", {31'd0, par_oe_o}, 32'd1);
    @(negedge clk);
    check("R4", {31'd0, par_oe_o}, 32'd0);
  endtask

  // kind 0: address, 1: data
  task automatic recv(input logic [31:0] a, input logic [3:0] c, input int kind,
                      input logic bad, input logic en, input logic w1c, input string req);
    logic exp_low;
    @(negedge clk);
    ad_i       = a;
    cbe_i      = c;
    chk_addr_i = (kind == 0);
    chk_data_i = (kind == 1);
    resp_en_i  = en;
    @(negedge clk);
    chk_addr_i = 1'b0;
    chk_data_i = 1'b0;
    ad_i       = ~a;
    par_i      = even_bit(a, c) ^ bad;
    stat_w1c_i = w1c;
    @(negedge clk);
    par_i      = 1'b0;
    stat_w1c_i = 1'b0;
    exp_low    = bad && (kind == 1) && en;
    if (bad) exp_dpe = 1'b1;
    else if (w1c) exp_dpe = 1'b0;
    check(req, {31'd0, perr_n_o}, {31'd0, ~exp_low});
    check(req, {31'd0, dpe_o}, {31'd0, exp_dpe});
    @(negedge clk);
    check(req, {31'd0, perr_n_o}, 32'd1);
  endtask

  task automatic clear_dpe();
    @(negedge clk);
    stat_w1c_i = 1'b1;
    @(negedge clk);
    stat_w1c_i = 1'b0;
    exp_dpe = 1'b0;
    check("R9", {31'd0, dpe_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] lfsr;
    n_chk = 0; n_fail = 0; cycles = 0; exp_dpe = 1'b0;
    rst_n = 1'b0;
    drv_addr_i = 0; drv_data_i = 0; gnt_i = 0; req_i = 0; bus_idle_i = 0;
    ad_src_i = '0; cbe_src_i = '0; ad_i = '0; cbe_i = '0; par_i = 0;
    chk_addr_i = 0; chk_data_i = 0; resp_en_i = 0; stat_w1c_i = 0;
    repeat (3) @(negedge clk);
    check("R10", {ad_oe_o, cbe_oe_o, par_oe_o, dpe_o}, 4'b0000);
    check("R10", {31'd0, perr_n_o}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {ad_oe_o, par_oe_o, dpe_o, perr_n_o}, 4'b0001);

    // single-bit sweep over all 36 covered bits, each drive kind
    for (int i = 0; i < 36; i++) begin
      logic [35:0] v;
      v = 36'd1 << i;
      send(v[31:0], v[35:32], 0, "R1");
      send(v[31:0], v[35:32], 1, "R2");
      send(v[31:0], v[35:32], 2, "R3");
    end

    // pseudo-random patterns
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr, lfsr[7:4] ^ lfsr[3:0], i % 3, (i % 3 == 0) ? "R1" : (i % 3 == 1) ? "R2" : "R3");
    end

    // grant while requesting, nothing else active: no drive
    @(negedge clk);
    gnt_i = 1'b1; req_i = 1'b1; bus_idle_i = 1'b1;
    #1;
    check("R3", {ad_oe_o, cbe_oe_o}, 2'b00);
    @(negedge clk);
    gnt_i = 1'b0; req_i = 1'b0; bus_idle_i = 1'b0;
    check("R4", {31'd0, par_oe_o}, 32'd0);

    // receive sweep: good and bad parity for every single-bit word
    for (int i = 0; i < 36; i++) begin
      logic [35:0] v;
      v = 36'd1 << i;
      recv(v[31:0], v[35:32], 0, 1'b0, 1'b1, 1'b0, "R8");
      recv(v[31:0], v[35:32], 1, 1'b0, 1'b1, 1'b0, "R8");
      recv(v[31:0], v[35:32], 0, 1'b1, 1'b1, 1'b0, "R5");
      clear_dpe();
      recv(v[31:0], v[35:32], 1, 1'b1, 1'b1, 1'b0, "R6");
      clear_dpe();
      recv(v[31:0], v[35:32], 1, 1'b1, 1'b0, 1'b0, "R7");
      clear_dpe();
    end

    // clear strobe colliding with detection
    recv(32'h1234_5678, 4'hA, 1, 1'b1, 1'b1, 1'b1, "R9");
    recv(32'h0F0F_0F0F, 4'h3, 0, 1'b1, 1'b0, 1'b1, "R9");
    recv(32'hFFFF_0000, 4'h1, 1, 1'b0, 1'b1, 1'b1, "R9");
    recv(32'hDEAD_BEEF, 4'hF, 1, 1'b0, 1'b1, 1'b0, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule